// File: doc/BRIEF.md
# ARP Address Resolver with Retry

This block sits on the transmit side of an IPv4 stack and turns a destination IPv4 address into the 48-bit Ethernet address that the frame builder needs. A client pulses a lookup request with a 32-bit address. If the single cached binding is valid and holds that address, the resolver answers in the next cycle. Otherwise it strobes an ARP frame builder to broadcast a request, then waits for a matching reply from the receive side.

If no reply arrives within a configurable timeout, the resolver strobes the builder again. After a configurable number of unanswered attempts it reports an error pulse and returns to idle. Every binding delivered on the receive input is learned into the cache, and the cache entry expires after a long idle period unless it is refreshed. A parameter can switch resolution off. In that mode every lookup is answered at once with a fixed default address.

Top module: `arp_resolver`

## Requirements
- R1: During and after reset, `lkp_got_o`, `lkp_err_o` and `arp_send_o` are 0, `lkp_mac_o` equals `DEFAULT_MAC`, and the cache is empty, so the first lookup misses.
- R2: A request sampled while the cache is valid and holds the requested IP produces `lkp_got_o`=1 with the cached MAC in the following cycle, and `arp_send_o` stays 0.
- R3: On a miss, `arp_send_o` pulses for one cycle exactly two clock edges after the request edge. `arp_tgt_ip_o` equals the requested IP and `arp_dst_mac_o` is all ones.
- R4: While waiting, a binding with `bind_valid_i`=1, `bind_reply_i`=1 and an IP equal to the pending one gives `lkp_got_o`=1 in the next cycle, with `lkp_mac_o` equal to that binding's MAC, and later lookups of that IP hit.
- R5: While waiting, a binding with a different IP, or with `bind_reply_i`=0, does not complete the lookup.
- R6: Without a reply, consecutive `arp_send_o` pulses are `REPLY_TIMEOUT`+1 cycles apart.
- R7: After `MAX_TRIES` unanswered sends, `lkp_err_o` pulses once (never together with `lkp_got_o`) and the resolver returns to idle and accepts new lookups.
- R8: A successful reply clears the attempt count, so the next unanswered lookup again makes exactly `MAX_TRIES` sends.
- R9: A binding written at edge W serves lookups sampled up to edge W+`AGE_LIMIT` and misses for requests sampled later.
- R10: Every binding write restarts the expiry count. A write at the same edge as the expiry keeps the binding valid.
- R11: A matching reply sampled at the same edge as the reply timeout completes the lookup, and no further send follows.
- R12: A lookup request sampled while a resolution is in progress is ignored. No answer is given for it, and the pending IP is unchanged.
- R13: With `ENABLE_RESOLVE`=0, every request is answered in the next cycle with `lkp_got_o`=1 and `lkp_mac_o`=`DEFAULT_MAC`, and `arp_send_o` never pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lkp_req_i | input | 1 | Lookup request strobe |
| lkp_ip_i | input | IP_W | Address to resolve |
| lkp_mac_o | output | MAC_W | Resolved MAC, valid with `lkp_got_o` |
| lkp_got_o | output | 1 | One-cycle success pulse |
| lkp_err_o | output | 1 | One-cycle failure pulse after all attempts |
| arp_send_o | output | 1 | One-cycle strobe to the ARP frame builder |
| arp_tgt_ip_o | output | IP_W | Address to query in the ARP request |
| arp_dst_mac_o | output | MAC_W | Destination MAC of the request, broadcast |
| bind_valid_i | input | 1 | A received binding is present |
| bind_ip_i | input | IP_W | IP of the received binding |
| bind_mac_i | input | MAC_W | MAC of the received binding |
| bind_reply_i | input | 1 | The binding came from an ARP reply |

## Verification
Two pairs of events can land on the same clock edge. The first is a binding write and the cache expiry. The second is a matching reply and the reply timeout. The bench places a refresh write exactly `AGE_LIMIT` cycles after the previous write, and the binding must survive for a full new period. It also drives a matching reply in the very cycle the timer reaches its limit, and the lookup must complete with no further send and no error. Each edge is reached by counting falling edges from an observed output pulse, so the collision is exact rather than approximate.

// File: rtl/arp_resolver_pkg.sv
// Shared types for the ARP resolver: controller state encoding.
package arp_resolver_pkg;
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_WAIT   = 2'd2
    } rslv_state_e;
endpackage

// File: rtl/arp_bind_cache.sv
// Single-entry binding store with idle expiry.
// Any write loads IP and MAC, sets valid and restarts the age count.
// When no write arrives, valid drops AGE_LIMIT cycles after the last write.
// A write wins over an expiry that falls on the same edge.
// Assumes AGE_LIMIT >= 2.
module arp_bind_cache #(
    parameter int          IP_W      = 32,
    parameter int          MAC_W     = 48,
    parameter int unsigned AGE_LIMIT = 32'd2500000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_i,
    input  logic [IP_W-1:0]  wr_ip_i,
    input  logic [MAC_W-1:0] wr_mac_i,
    output logic             valid_o,
    output logic [IP_W-1:0]  ip_o,
    output logic [MAC_W-1:0] mac_o
);
    localparam int AGE_W = $clog2(AGE_LIMIT + 1);
    localparam logic [AGE_W-1:0] AGE_LAST = AGE_W'(AGE_LIMIT - 1);

    logic [AGE_W-1:0] age_q;

    // Load on write, otherwise age the valid entry and drop it at the limit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_o <= 1'b0;
            ip_o    <= '0;
            mac_o   <= '0;
            age_q   <= '0;
        end else if (wr_i) begin
            valid_o <= 1'b1;
            ip_o    <= wr_ip_i;
            mac_o   <= wr_mac_i;
            age_q   <= '0;
        end else if (valid_o) begin
            if (age_q == AGE_LAST) begin
                valid_o <= 1'b0;
                age_q   <= '0;
            end else begin
                age_q <= age_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/arp_retry_fsm.sv
// Resolution controller: answers hits from the cache, otherwise issues
// ARP send strobes, waits REPLY_TIMEOUT cycles per attempt, and gives up
// with an error pulse after MAX_TRIES attempts. A matching reply wins over
// a timeout on the same edge. Requests outside idle are ignored.
// Assumes REPLY_TIMEOUT >= 1 and MAX_TRIES >= 1.
module arp_retry_fsm
    import arp_resolver_pkg::*;
#(
    parameter int             IP_W          = 32,
    parameter int             MAC_W         = 48,
    parameter int unsigned    REPLY_TIMEOUT = 125000000,
    parameter int             MAX_TRIES     = 10,
    parameter logic [MAC_W-1:0] RESET_MAC   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_i,
    input  logic [IP_W-1:0]  req_ip_i,
    input  logic             cache_valid_i,
    input  logic [IP_W-1:0]  cache_ip_i,
    input  logic [MAC_W-1:0] cache_mac_i,
    input  logic             bind_valid_i,
    input  logic [IP_W-1:0]  bind_ip_i,
    input  logic [MAC_W-1:0] bind_mac_i,
    input  logic             bind_reply_i,
    output logic             got_o,
    output logic             err_o,
    output logic [MAC_W-1:0] mac_o,
    output logic             send_o,
    output logic [IP_W-1:0]  tgt_ip_o
);
    localparam int TMR_W = $clog2(REPLY_TIMEOUT + 1);
    localparam int TRY_W = $clog2(MAX_TRIES + 1);
    localparam logic [TMR_W-1:0] TMR_LAST = TMR_W'(REPLY_TIMEOUT - 1);
    localparam logic [TRY_W-1:0] TRY_LAST = TRY_W'(MAX_TRIES);

    rslv_state_e      state_q;
    logic [TMR_W-1:0] timer_q;
    logic [TRY_W-1:0] tries_q;
    logic             hit;
    logic             reply_ok;
    logic             tmr_done;

    // Decode cache hit, matching reply and timer expiry for this cycle.
    always_comb begin
        hit      = cache_valid_i && (cache_ip_i == req_ip_i);
        reply_ok = bind_valid_i && bind_reply_i && (bind_ip_i == tgt_ip_o);
        tmr_done = (timer_q == TMR_LAST);
    end

    // Sequence idle -> send -> wait, with retries, answers and error pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            timer_q  <= '0;
            tries_q  <= '0;
            tgt_ip_o <= '0;
            got_o    <= 1'b0;
            err_o    <= 1'b0;
            send_o   <= 1'b0;
            mac_o    <= RESET_MAC;
        end else begin
            got_o  <= 1'b0;
            err_o  <= 1'b0;
            send_o <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_i) begin
                        if (hit) begin
                            got_o <= 1'b1;
                            mac_o <= cache_mac_i;
                        end else begin
                            tgt_ip_o <= req_ip_i;
                            state_q  <= ST_LOOKUP;
                        end
                    end
                end
                ST_LOOKUP: begin
                    send_o  <= 1'b1;
                    tries_q <= tries_q + 1'b1;
                    timer_q <= '0;
                    state_q <= ST_WAIT;
                end
                ST_WAIT: begin
                    if (reply_ok) begin
                        got_o   <= 1'b1;
                        mac_o   <= bind_mac_i;
                        tries_q <= '0;
                        state_q <= ST_IDLE;
                    end else if (tmr_done) begin
                        if (tries_q == TRY_LAST) begin
                            err_o   <= 1'b1;
                            tries_q <= '0;
                            state_q <= ST_IDLE;
                        end else begin
                            state_q <= ST_LOOKUP;
                        end
                    end else begin
                        timer_q <= timer_q + 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/arp_resolver.sv
// Top of the ARP resolver. With ENABLE_RESOLVE set it combines the binding
// cache and the retry controller, and every received binding is learned.
// With ENABLE_RESOLVE clear it answers every lookup with DEFAULT_MAC.
// Assumes bindings and requests are already in this clock domain.
module arp_resolver #(
    parameter int               IP_W           = 32,
    parameter int               MAC_W          = 48,
    parameter int unsigned      REPLY_TIMEOUT  = 125000000,
    parameter int               MAX_TRIES      = 10,
    parameter int unsigned      AGE_LIMIT      = 32'd2500000000,
    parameter bit               ENABLE_RESOLVE = 1'b1,
    parameter logic [MAC_W-1:0] DEFAULT_MAC    = 48'h02_00_5E_10_20_30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lkp_req_i,
    input  logic [IP_W-1:0]  lkp_ip_i,
    output logic [MAC_W-1:0] lkp_mac_o,
    output logic             lkp_got_o,
    output logic             lkp_err_o,
    output logic             arp_send_o,
    output logic [IP_W-1:0]  arp_tgt_ip_o,
    output logic [MAC_W-1:0] arp_dst_mac_o,
    input  logic             bind_valid_i,
    input  logic [IP_W-1:0]  bind_ip_i,
    input  logic [MAC_W-1:0] bind_mac_i,
    input  logic             bind_reply_i
);
    // Requests always go to the broadcast address.
    assign arp_dst_mac_o = '1;

    generate
        if (ENABLE_RESOLVE) begin : g_resolve
            logic             c_valid;
            logic [IP_W-1:0]  c_ip;
            logic [MAC_W-1:0] c_mac;

            arp_bind_cache #(
                .IP_W(IP_W), .MAC_W(MAC_W), .AGE_LIMIT(AGE_LIMIT)
            ) u_cache (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_i    (bind_valid_i),
                .wr_ip_i (bind_ip_i),
                .wr_mac_i(bind_mac_i),
                .valid_o (c_valid),
                .ip_o    (c_ip),
                .mac_o   (c_mac)
            );

            arp_retry_fsm #(
                .IP_W(IP_W), .MAC_W(MAC_W), .REPLY_TIMEOUT(REPLY_TIMEOUT),
                .MAX_TRIES(MAX_TRIES), .RESET_MAC(DEFAULT_MAC)
            ) u_fsm (
                .clk          (clk),
                .rst_n        (rst_n),
                .req_i        (lkp_req_i),
                .req_ip_i     (lkp_ip_i),
                .cache_valid_i(c_valid),
                .cache_ip_i   (c_ip),
                .cache_mac_i  (c_mac),
                .bind_valid_i (bind_valid_i),
                .bind_ip_i    (bind_ip_i),
                .bind_mac_i   (bind_mac_i),
                .bind_reply_i (bind_reply_i),
                .got_o        (lkp_got_o),
                .err_o        (lkp_err_o),
                .mac_o        (lkp_mac_o),
                .send_o       (arp_send_o),
                .tgt_ip_o     (arp_tgt_ip_o)
            );
        end else begin : g_fixed
            // Answer each request with the fixed address one cycle later.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    lkp_got_o <= 1'b0;
                    lkp_mac_o <= DEFAULT_MAC;
                end else begin
                    lkp_got_o <= lkp_req_i;
                    lkp_mac_o <= DEFAULT_MAC;
                end
            end
            assign lkp_err_o    = 1'b0;
            assign arp_send_o   = 1'b0;
            assign arp_tgt_ip_o = '0;
        end
    endgenerate
endmodule

// File: rtl/arp_resolver_chk.sv
// Property checker for arp_resolver, bound to every instance.
module arp_resolver_chk #(
    parameter int MAX_TRIES      = 10,
    parameter bit ENABLE_RESOLVE = 1'b1
) (
    input logic clk,
    input logic rst_n,
    input logic lkp_got_o,
    input logic lkp_err_o,
    input logic arp_send_o
);
    localparam int CNT_W = $clog2(MAX_TRIES + 2);
    logic [CNT_W-1:0] sends_q;

    // Count send strobes since the last answer or error.
    always_ff @(posedge clk) begin
        if (!rst_n)                      sends_q <= '0;
        else if (lkp_got_o || lkp_err_o) sends_q <= '0;
        else if (arp_send_o)             sends_q <= sends_q + 1'b1;
    end

    a_r7_got_err_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(lkp_got_o && lkp_err_o));

    a_r2_got_without_send: assert property (@(posedge clk) disable iff (!rst_n)
        lkp_got_o |-> !arp_send_o);

    a_r3_send_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        arp_send_o |=> !arp_send_o);

    a_r7_attempt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        sends_q <= CNT_W'(MAX_TRIES));

    generate
        if (!ENABLE_RESOLVE) begin : g_off
            a_r13_no_send_when_off: assert property (@(posedge clk) disable iff (!rst_n)
                !arp_send_o && !lkp_err_o);
        end
    endgenerate
endmodule

bind arp_resolver arp_resolver_chk #(
    .MAX_TRIES(MAX_TRIES), .ENABLE_RESOLVE(ENABLE_RESOLVE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .lkp_got_o (lkp_got_o),
    .lkp_err_o (lkp_err_o),
    .arp_send_o(arp_send_o)
);

// File: tb/arp_resolver_bench.sv
module arp_resolver_bench;
    localparam int          T     = 20;
    localparam int          TRIES = 4;
    localparam int unsigned AGE   = 300;
    localparam logic [47:0] DEF_MAC = 48'h02_00_00_00_00_99;

    localparam logic [31:0] IP_A = 32'h0A00_0001, IP_B = 32'h0A00_0002,
                            IP_C = 32'h0A00_0003, IP_D = 32'h0A00_0004,
                            IP_E = 32'h0A00_0005, IP_F = 32'h0A00_0006,
                            IP_G = 32'h0A00_0007, IP_H = 32'h0A00_0008;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;

    logic        req = 1'b0, bind_v = 1'b0, bind_rep = 1'b0;
    logic [31:0] req_ip = '0, bind_ip = '0;
    logic [47:0] bind_mac = '0;

    logic        got, err, send, got2, err2, send2;
    logic [47:0] mac, dst, mac2, dst2;
    logic [31:0] tgt, tgt2;

    int n_tests = 0, n_fail = 0, off_sends = 0;
    bit wd = 1'b0;

    arp_resolver #(.REPLY_TIMEOUT(T), .MAX_TRIES(TRIES), .AGE_LIMIT(AGE),
                   .ENABLE_RESOLVE(1'b1), .DEFAULT_MAC(DEF_MAC)) u_arp_resolver (
        .clk(clk), .rst_n(rst_n), .lkp_req_i(req), .lkp_ip_i(req_ip),
        .lkp_mac_o(mac), .lkp_got_o(got), .lkp_err_o(err), .arp_send_o(send),
        .arp_tgt_ip_o(tgt), .arp_dst_mac_o(dst), .bind_valid_i(bind_v),
        .bind_ip_i(bind_ip), .bind_mac_i(bind_mac), .bind_reply_i(bind_rep));

    arp_resolver #(.REPLY_TIMEOUT(T), .MAX_TRIES(TRIES), .AGE_LIMIT(AGE),
                   .ENABLE_RESOLVE(1'b0), .DEFAULT_MAC(DEF_MAC)) u_arp_resolver_off (
        .clk(clk), .rst_n(rst_n), .lkp_req_i(req), .lkp_ip_i(req_ip),
        .lkp_mac_o(mac2), .lkp_got_o(got2), .lkp_err_o(err2), .arp_send_o(send2),
        .arp_tgt_ip_o(tgt2), .arp_dst_mac_o(dst2), .bind_valid_i(bind_v),
        .bind_ip_i(bind_ip), .bind_mac_i(bind_mac), .bind_reply_i(bind_rep));

    always @(negedge clk) if (rst_n && (send2 || err2)) off_sends++;

    task automatic check(input bit ok, input string tag,
                         input logic [63:0] act, input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Drive a one-cycle request from the current falling edge.
    task automatic do_req(input logic [31:0] ip);
        req = 1'b1; req_ip = ip;
        @(negedge clk);
        req = 1'b0;
    endtask

    // Drive a one-cycle received binding from the current falling edge.
    task automatic do_bind(input logic [31:0] ip, input logic [47:0] m, input logic rep);
        bind_v = 1'b1; bind_ip = ip; bind_mac = m; bind_rep = rep;
        @(negedge clk);
        bind_v = 1'b0; bind_rep = 1'b0;
    endtask

    task automatic wait_send(output int waited);
        waited = 0;
        while (!send && waited < 1000) begin
            @(negedge clk);
            waited++;
        end
    endtask

    // Run one lookup to the error pulse, counting sends and the gap between them.
    task automatic run_to_error(output int sends, output int gap, output int errs);
        int first = -1;
        sends = 0; gap = 0; errs = 0;
        for (int i = 0; i < (T + 2) * TRIES + 20; i++) begin
            @(negedge clk);
            if (send) begin
                if (sends == 0) first = i;
                else if (sends == 1) gap = i - first;
                sends++;
            end
            if (err) begin
                errs++;
                break;
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!got && !err && !send, "R1 outputs idle in reset", {61'd0, got, err, send}, 0);
        check(mac == DEF_MAC, "R1 reset mac", mac, DEF_MAC);
        check(!got2 && mac2 == DEF_MAC, "R1 fixed-mode reset", mac2, DEF_MAC);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_miss_reply();
        int w;
        do_req(IP_A);
        check(!got, "R1 empty cache misses", got, 0);
        wait_send(w);
        check(w == 1, "R3 send two edges after request", w, 1);
        check(tgt == IP_A, "R3 target ip", tgt, IP_A);
        check(dst == 48'hFFFF_FFFF_FFFF, "R3 broadcast destination", dst, 48'hFFFF_FFFF_FFFF);
        do_bind(IP_B, 48'hBB, 1'b1);
        check(!got, "R5 reply for other ip ignored", got, 0);
        do_bind(IP_A, 48'hEE, 1'b0);
        check(!got, "R5 binding without reply flag ignored", got, 0);
        do_bind(IP_A, 48'hAA, 1'b1);
        check(got && mac == 48'hAA, "R4 matching reply answers", mac, 48'hAA);
        @(negedge clk);
    endtask

    task automatic t_hit();
        bit quiet = 1'b1;
        do_req(IP_A);
        check(got && mac == 48'hAA, "R2 hit answers next cycle", {got, mac}, {1'b1, 48'hAA});
        for (int i = 0; i < 4; i++) begin
            if (send) quiet = 1'b0;
            @(negedge clk);
        end
        check(quiet, "R2 hit sends nothing", !quiet, 0);
    endtask

    task automatic t_busy();
        int w;
        bit silent = 1'b1;
        do_req(IP_C);
        wait_send(w);
        do_req(IP_A);
        for (int i = 0; i < 3; i++) begin
            if (got) silent = 1'b0;
            @(negedge clk);
        end
        check(silent, "R12 request while busy ignored", !silent, 0);
        do_bind(IP_C, 48'hCC, 1'b1);
        check(got && mac == 48'hCC, "R12 pending ip kept", mac, 48'hCC);
        @(negedge clk);
    endtask

    task automatic t_retry();
        int s, g, e;
        do_req(IP_D);
        run_to_error(s, g, e);
        check(s == TRIES, "R7 send count before error", s, TRIES);
        check(g == T + 1, "R6 resend spacing", g, T + 1);
        check(e == 1 && !got, "R7 error pulse", e, 1);
        @(negedge clk);
        do_req(IP_C);
        check(got && mac == 48'hCC, "R7 idle again after error", mac, 48'hCC);
        @(negedge clk);
    endtask

    task automatic t_clear();
        int s = 0, g, e;
        do_req(IP_E);
        for (int i = 0; i < (T + 2) * TRIES && s < TRIES; i++) begin
            @(negedge clk);
            if (send) s++;
        end
        do_bind(IP_E, 48'hE5, 1'b1);
        check(got && mac == 48'hE5, "R8 reply on last attempt", mac, 48'hE5);
        @(negedge clk);
        do_req(IP_F);
        run_to_error(s, g, e);
        check(s == TRIES && e == 1, "R8 attempt count cleared by success", s, TRIES);
        @(negedge clk);
    endtask

    task automatic t_race();
        int w;
        bit quiet = 1'b1;
        do_req(IP_G);
        wait_send(w);
        repeat (T - 1) @(negedge clk);
        do_bind(IP_G, 48'h66, 1'b1);
        check(got && mac == 48'h66, "R11 reply at timeout edge wins", mac, 48'h66);
        for (int i = 0; i < T + 5; i++) begin
            @(negedge clk);
            if (send || err) quiet = 1'b0;
        end
        check(quiet, "R11 no resend after reply", !quiet, 0);
    endtask

    task automatic t_age();
        int w;
        do_bind(IP_H, 48'h81, 1'b0);
        repeat (AGE - 1) @(negedge clk);
        do_bind(IP_H, 48'h82, 1'b0);
        do_req(IP_H);
        check(got && mac == 48'h82, "R10 refresh on expiry edge kept", {got, mac}, {1'b1, 48'h82});
        repeat (AGE - 2) @(negedge clk);
        do_req(IP_H);
        check(got, "R9 hit on last valid edge", got, 1);
        do_req(IP_H);
        check(!got, "R9 miss after expiry", got, 0);
        wait_send(w);
        check(w == 1, "R9 expired entry triggers send", w, 1);
        do_bind(IP_H, 48'h83, 1'b1);
        check(got && mac == 48'h83, "R4 resolve after expiry", mac, 48'h83);
        @(negedge clk);
    endtask

    task automatic t_off();
        check(!got2, "R13 fixed mode idle", got2, 0);
        do_req(IP_B);
        check(got2 && mac2 == DEF_MAC, "R13 fixed answer", mac2, DEF_MAC);
        @(negedge clk);
        check(off_sends == 0, "R13 fixed mode never sends", off_sends, 0);
    endtask

    initial begin
        fork
            begin
                t_reset();
                t_miss_reply();
                t_hit();
                t_busy();
                t_retry();
                t_clear();
                t_race();
                t_age();
                t_off();
            end
            begin
                repeat (150000) @(posedge clk);
                wd = 1'b1;
            end
        join_any
        if (wd) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule